// File: doc/BRIEF.md
# Floating-Point Compare and Predicate Unit

This block takes two 32-bit binary floating-point operands together with a valid strobe and, one clock later, presents a registered set of relational results: less, equal, greater and unordered, plus the derived not-equal and less-or-greater outputs. For each operand it also reports whether the value is a NaN and whether it is finite. The operands are ordered by treating their raw encodings as sign-magnitude integers. Corrections are then applied for the sign, for the two encodings of zero, and for NaNs.

A one-bit mode input picks a quiet or an ordered (signaling-style) comparison. In ordered mode, a NaN operand raises an invalid flag. The unit does no arithmetic, performs no conversions and raises no traps. The invalid flag is there for the surrounding pipeline to collect.

Top module: `fcmp_unit`

## Requirements
- R1: An operand whose exponent field (bits 30:23) is all ones and whose fraction (bits 22:0) is non-zero is a NaN, whatever bit 31 holds. Its per-operand NaN output is 1.
- R2: If either operand is a NaN, `res_unord` is 1 and `res_lt`, `res_eq` and `res_gt` are 0. This holds even when both operands carry the identical NaN encoding.
- R3: +0 (0x00000000) and -0 (0x80000000) compare equal in every pairing: `res_eq`=1, `res_lt`=`res_gt`=0.
- R4: If the sign bits (bit 31) differ and the operands are not both zero, the operand with sign 1 is the lesser.
- R5: If both operands have sign 0, their order is the unsigned order of bits 30:0. If both have sign 1, that order is reversed.
- R6: Each infinity (exponent all ones, fraction 0) equals itself. +inf is greater than every finite value and -inf is less than every finite value.
- R7: `res_lg` equals `res_lt | res_gt`, so it is 0 for NaN operands. `res_ne` equals `!res_eq`, so it is 1 for NaN operands.
- R8: The per-operand finite output is 1 exactly when the exponent field is not all ones.
- R9: `res_inv` is 1 when `in_sig` was 1 and at least one operand is a NaN. Otherwise it is 0.
- R10: All result outputs are registered. `res_vld` follows `in_vld` by exactly one clock, and results change only on a cycle where `in_vld` was 1. A synchronous active-high reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operand valid strobe |
| in_a | input | 32 | Operand A encoding |
| in_b | input | 32 | Operand B encoding |
| in_sig | input | 1 | 1 = ordered comparison (NaN raises invalid), 0 = quiet |
| res_vld | output | 1 | Result valid, one clock after in_vld |
| res_lt | output | 1 | A < B |
| res_eq | output | 1 | A == B |
| res_gt | output | 1 | A > B |
| res_unord | output | 1 | At least one operand is NaN |
| res_ne | output | 1 | Not equal (inverse of res_eq) |
| res_lg | output | 1 | Less or greater |
| res_inv | output | 1 | Invalid: ordered compare met a NaN |
| a_nan | output | 1 | Operand A is NaN |
| b_nan | output | 1 | Operand B is NaN |
| a_fin | output | 1 | Operand A is finite |
| b_fin | output | 1 | Operand B is finite |

## Verification
The hardest cases to reach sit at the edges of the encoding. One is a NaN whose fraction has only its lowest bit set, since it sits right next to an infinity. Others are a pair made of the identical NaN, and the mixed-sign zero pair, where a plain integer compare would call the operands unequal. Random stimulus almost never produces these. The bench therefore drives them as directed vectors, and then adds a pseudo-random sweep biased toward negative pairs, special exponents and equal operands. A reference function in the bench works out the expected order from the decoded values.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int unsigned FP_W   = 32;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned FRAC_W = FP_W - 1 - EXP_W;
  localparam int unsigned MAG_W  = FP_W - 1;

  typedef struct packed {
    logic is_nan;
    logic is_fin;
    logic is_zero;
    logic sign;
  } fp_class_t;

  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
    logic un;
  } rel_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int unsigned W  = 32,
  parameter int unsigned EW = 8
) (
  input  logic              [W-1:0] op,
  output fcmp_pkg::fp_class_t       cls
);
  localparam int unsigned FW = W - 1 - EW;
  logic [EW-1:0] expf;
  logic [FW-1:0] frac;
  logic          exp_max;

  assign expf    = op[W-2 -: EW];
  assign frac    = op[FW-1:0];
  assign exp_max = &expf;

  always_comb begin
    cls.sign    = op[W-1];
    cls.is_fin  = !exp_max;
    cls.is_nan  = exp_max && (|frac);
    cls.is_zero = (op[W-2:0] == '0);
  end
endmodule

// File: rtl/fcmp_core.sv
module fcmp_core #(
  parameter int unsigned W = 32
) (
  input  logic                [W-1:0] a,
  input  logic                [W-1:0] b,
  input  fcmp_pkg::fp_class_t         ca,
  input  fcmp_pkg::fp_class_t         cb,
  output fcmp_pkg::rel_t              rel
);
  localparam int unsigned MW = W - 1;
  logic [MW-1:0] ma, mb;
  logic mag_lt, mag_eq, both_zero, unord;

  assign ma        = a[MW-1:0];
  assign mb        = b[MW-1:0];
  assign mag_lt    = ma < mb;
  assign mag_eq    = ma == mb;
  assign both_zero = ca.is_zero && cb.is_zero;
  assign unord     = ca.is_nan || cb.is_nan;

  always_comb begin
    rel = '0;
    if (unord) begin
      rel.un = 1'b1;
    end else if (both_zero) begin
      rel.eq = 1'b1;
    end else if (ca.sign != cb.sign) begin
      rel.lt = ca.sign;
      rel.gt = cb.sign;
    end else if (mag_eq && (a[W-1] == b[W-1])) begin
      rel.eq = 1'b1;
    end else if (!ca.sign) begin
      rel.lt = mag_lt;
      rel.gt = !mag_lt;
    end else begin
      rel.lt = !mag_lt;
      rel.gt = mag_lt;
    end
  end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit #(
  parameter int unsigned FP_W  = 32,
  parameter int unsigned EXP_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_vld,
  input  logic [FP_W-1:0] in_a,
  input  logic [FP_W-1:0] in_b,
  input  logic            in_sig,
  output logic            res_vld,
  output logic            res_lt,
  output logic            res_eq,
  output logic            res_gt,
  output logic            res_unord,
  output logic            res_ne,
  output logic            res_lg,
  output logic            res_inv,
  output logic            a_nan,
  output logic            b_nan,
  output logic            a_fin,
  output logic            b_fin
);
  fcmp_pkg::fp_class_t ca, cb;
  fcmp_pkg::rel_t      rel;

  fcmp_classify #(.W(FP_W), .EW(EXP_W)) u_cls_a (.op(in_a), .cls(ca));
  fcmp_classify #(.W(FP_W), .EW(EXP_W)) u_cls_b (.op(in_b), .cls(cb));
  fcmp_core     #(.W(FP_W))             u_core  (.a(in_a), .b(in_b), .ca(ca), .cb(cb), .rel(rel));

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld   <= 1'b0;
      res_lt    <= 1'b0;
      res_eq    <= 1'b0;
      res_gt    <= 1'b0;
      res_unord <= 1'b0;
      res_ne    <= 1'b0;
      res_lg    <= 1'b0;
      res_inv   <= 1'b0;
      a_nan     <= 1'b0;
      b_nan     <= 1'b0;
      a_fin     <= 1'b0;
      b_fin     <= 1'b0;
    end else begin
      res_vld <= in_vld;
      if (in_vld) begin
        res_lt    <= rel.lt;
        res_eq    <= rel.eq;
        res_gt    <= rel.gt;
        res_unord <= rel.un;
        res_ne    <= !rel.eq;
        res_lg    <= rel.lt | rel.gt;
        res_inv   <= in_sig & rel.un;
        a_nan     <= ca.is_nan;
        b_nan     <= cb.is_nan;
        a_fin     <= ca.is_fin;
        b_fin     <= cb.is_fin;
      end
    end
  end
endmodule

// File: rtl/fcmp_unit_chk.sv
module fcmp_unit_chk (
  input logic clk,
  input logic rst,
  input logic in_vld,
  input logic res_vld,
  input logic res_lt,
  input logic res_eq,
  input logic res_gt,
  input logic res_unord,
  input logic res_ne,
  input logic res_lg,
  input logic res_inv,
  input logic a_nan,
  input logic b_nan,
  input logic a_fin,
  input logic b_fin
);
  AST_ONE_RELATION: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> $countones({res_lt, res_eq, res_gt, res_unord}) == 1); // R2
  AST_UNORD_NAN: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> (res_unord == (a_nan | b_nan))); // R2
  AST_NAN_NOT_FIN: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> !(a_nan && a_fin) && !(b_nan && b_fin)); // R8
  AST_DERIVED: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> (res_ne == !res_eq) && (res_lg == (res_lt | res_gt))); // R7
  AST_INV_NEEDS_NAN: assert property (@(posedge clk) disable iff (rst)
    res_inv |-> res_unord); // R9
  AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> res_vld); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(in_vld) && !$past(rst)) |-> $stable({res_lt, res_eq, res_gt, res_unord, res_inv})); // R10
endmodule

bind fcmp_unit fcmp_unit_chk u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .res_vld(res_vld),
  .res_lt(res_lt), .res_eq(res_eq), .res_gt(res_gt), .res_unord(res_unord),
  .res_ne(res_ne), .res_lg(res_lg), .res_inv(res_inv),
  .a_nan(a_nan), .b_nan(b_nan), .a_fin(a_fin), .b_fin(b_fin)
);

// File: tb/fcmp_unit_bench.sv
module fcmp_unit_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic [31:0] in_a = '0, in_b = '0;
  logic in_sig = 1'b0;
  logic res_vld, res_lt, res_eq, res_gt, res_unord, res_ne, res_lg, res_inv;
  logic a_nan, b_nan, a_fin, b_fin;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fcmp_unit u_fcmp_unit (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_a(in_a), .in_b(in_b), .in_sig(in_sig),
    .res_vld(res_vld), .res_lt(res_lt), .res_eq(res_eq), .res_gt(res_gt),
    .res_unord(res_unord), .res_ne(res_ne), .res_lg(res_lg), .res_inv(res_inv),
    .a_nan(a_nan), .b_nan(b_nan), .a_fin(a_fin), .b_fin(b_fin)
  );

  typedef struct packed {
    logic [11:0] bits; // lt eq gt un ne lg inv anan bnan afin bfin vld
    logic [31:0] a;
    logic [31:0] b;
  } exp_t;
  exp_t q[$];

  function automatic bit is_nan(logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  // Reference: map encoding to a monotone integer key, then compare
  function automatic logic [32:0] key(logic [31:0] x);
    if (x[30:0] == 0) return 33'h100000000;
    if (x[31]) return 33'h100000000 - {2'b0, x[30:0]};
    return 33'h100000000 + {2'b0, x[30:0]};
  endfunction

  function automatic logic [11:0] model(logic [31:0] a, logic [31:0] b, logic sig);
    logic lt, eq, gt, un;
    un = is_nan(a) || is_nan(b);
    lt = !un && (key(a) < key(b));
    gt = !un && (key(a) > key(b));
    eq = !un && (key(a) == key(b));
    return {lt, eq, gt, un, !eq, lt | gt, sig & un, is_nan(a), is_nan(b),
            a[30:23] != 8'hFF, b[30:23] != 8'hFF, 1'b1};
  endfunction

  string tag_q[$];

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic sig, input string tag);
    exp_t e;
    @(negedge clk);
    in_vld = 1'b1; in_a = a; in_b = b; in_sig = sig;
    e.a = a; e.b = b; e.bits = model(a, b, sig);
    q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  // Monitor: sample mid-cycle after the registering edge
  always @(negedge clk) begin
    if (!rst && res_vld) begin
      exp_t e;
      string t;
      logic [11:0] got;
      got = {res_lt, res_eq, res_gt, res_unord, res_ne, res_lg, res_inv,
             a_nan, b_nan, a_fin, b_fin, res_vld};
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R10: unexpected res_vld actual=1 expected=0");
      end else begin
        e = q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (got !== e.bits) begin
          errors++;
          $display("FAIL %s: a=%h b=%h actual=%b expected=%b", t, e.a, e.b, got, e.bits);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    repeat (3) @(negedge clk);
    // Reset state R10
    checks++;
    if ({res_vld, res_lt, res_eq, res_gt, res_unord, res_ne, res_lg, res_inv, a_nan, b_nan, a_fin, b_fin} !== '0) begin
      errors++;
      $display("FAIL R10: reset outputs actual=nonzero expected=0");
    end
    rst = 1'b0;
    @(negedge clk);
    drive(32'h3F800000, 32'h40000000, 0, "R5");   // 1 < 2
    drive(32'hBF800000, 32'hC0000000, 0, "R5");   // -1 > -2
    drive(32'h40000000, 32'h40000000, 1, "R5");
    drive(32'h00000000, 32'h80000000, 1, "R3");
    drive(32'h80000000, 32'h00000000, 0, "R3");
    drive(32'h80000001, 32'h00000000, 0, "R4");
    drive(32'h80000000, 32'h00000001, 0, "R4");
    drive(32'hBF800000, 32'h3F800000, 0, "R4");
    drive(32'h7F800000, 32'h7F800000, 1, "R6");
    drive(32'hFF800000, 32'hFF800000, 1, "R6");
    drive(32'h7F800000, 32'h7F7FFFFF, 0, "R6");
    drive(32'hFF800000, 32'hFF7FFFFF, 0, "R6");
    drive(32'h7F800001, 32'h7F800000, 0, "R1");
    drive(32'hFFC00000, 32'h3F800000, 1, "R9");
    drive(32'h7FC00000, 32'h7FC00000, 0, "R2");
    drive(32'h7FC00000, 32'h7FC00000, 1, "R2");
    drive(32'h3F800000, 32'hFF800001, 1, "R9");
    drive(32'h7F800000, 32'h00000000, 0, "R8");
    drive(32'h00000001, 32'h007FFFFF, 0, "R7");
    // R10: idle cycles must not produce a result nor change outputs
    repeat (4) @(negedge clk);
    checks++;
    if (res_vld !== 1'b0 || res_lt !== 1'b1) begin
      errors++;
      $display("FAIL R10: idle hold actual=%b%b expected=01", res_vld, res_lt);
    end
    // pseudo-random sweep
    s = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      a = s;
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      b = s;
      if (i % 4 == 0) b = a;
      if (i % 5 == 1) begin a[31] = 1'b1; b[31] = 1'b1; end
      if (i % 7 == 2) a[30:23] = 8'hFF;
      if (i % 11 == 3) b[30:0] = '0;
      drive(a, b, s[0], "R5");
    end
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R10: missing results actual=%0d expected=0", q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule